// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts the direction of conditional branches from a table of small saturating counters. The counter that answers a lookup is picked from two things: a few low bits of the branch address, and a shift register holding the directions of the most recently resolved branches. Because of this, the same branch can get different predictions depending on the path that led to it.

A build-time parameter selects how the two sources form the table index. In the joined mode, the history bits sit above the address bits, so every address slot owns one counter per possible history value. In the hashed mode, the history is XORed into the address bits, so the table stays as large as the address field alone.

A lookup is purely combinational. It returns the predicted direction and the table index it used. When the branch resolves, the caller hands that same index back together with the real direction. On the next clock edge, the counter at that index moves one step and the outcome enters the history register. History is never updated speculatively.

Top module: `global_hist_predictor`

## Requirements
- R1: After reset the history register holds all zeros and every counter holds the weakly not-taken value 2^(n-1)-1, so every lookup predicts not taken.
- R2: With HASH_XOR=0 the lookup index is {history, pc index bits}, with the history in the upper bits.
- R3: With HASH_XOR=1 the lookup index is the pc index bits XORed with the zero-extended history.
- R4: Each resolve shifts the history left by one and puts the outcome (1 = taken) into bit 0. The new history takes effect in lookups from the next clock edge on.
- R5: A taken resolve increments the counter at the given index, and a counter already at 2^n-1 stays there.
- R6: A not-taken resolve decrements the counter at the given index, and a counter already at 0 stays there.
- R7: The prediction is taken exactly when the looked-up counter has its most significant bit set.
- R8: A resolve changes only the counter at the index supplied with it.
- R9: Cycles without a resolve change neither the history nor any counter.
- R10: The prediction and index respond to the lookup input in the same cycle, without a register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| predPcIdx | input | PC_BITS | Address index bits of the branch being looked up |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predIdx | output | IDX_W | Table index used for this prediction |
| resValid | input | 1 | A branch outcome is being reported this cycle |
| resIdx | input | IDX_W | Table index returned earlier with the prediction |
| resTaken | input | 1 | Real direction of the resolved branch, 1 = taken |

## Verification
The lookup outputs are due in the same cycle the address is applied. The bench therefore drives inputs just after a falling edge and samples them one nanosecond later, before the next rising edge. A resolve takes effect at the very next rising edge, and both its history shift and its counter step appear together in the lookup after that edge. The vector walk relies on this: each row checks the state left by the previous row's resolve. Saturation is proven by a later lookup that could only match the expected value if the counter had not wrapped.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  // Strobes from the control decision to the datapath
  typedef struct packed {
    logic ctrWr;      // write the counter at the resolve index
    logic ctrUp;      // 1 = increment, 0 = decrement
    logic histShift;  // shift an outcome into the history
    logic histBit;    // outcome to shift in
  } gbpStrobe_t;

endpackage

// File: rtl/gbp_ctrl.sv
module gbp_ctrl
  import gbp_pkg::*;
#(
  parameter int CTR_BITS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                resValid,
  input  logic                resTaken,
  input  logic [CTR_BITS-1:0] resCtr,
  output gbpStrobe_t          strb
);

  localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};

  logic atTop;
  logic atBottom;

  assign atTop    = (resCtr == CTR_MAX);
  assign atBottom = (resCtr == '0);

  always_comb begin
    strb.histShift = resValid;
    strb.histBit   = resTaken;
    strb.ctrUp     = resTaken;
    strb.ctrWr     = resValid && (resTaken ? !atTop : !atBottom);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!strb.ctrWr && !strb.histShift)); // R9

endmodule

// File: rtl/gbp_datapath.sv
module gbp_datapath
  import gbp_pkg::*;
#(
  parameter int HIST_BITS = 2,
  parameter int PC_BITS   = 4,
  parameter int CTR_BITS  = 2,
  parameter bit HASH_XOR  = 1'b0,
  parameter int IDX_W     = HASH_XOR ? PC_BITS : HIST_BITS + PC_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_BITS-1:0]  predPcIdx,
  output logic                predTaken,
  output logic [IDX_W-1:0]    predIdx,
  input  logic [IDX_W-1:0]    resIdx,
  output logic [CTR_BITS-1:0] resCtr,
  input  gbpStrobe_t          strb
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_BITS-1:0] CTR_INIT = (CTR_BITS)'((1 << (CTR_BITS - 1)) - 1);
  localparam logic [CTR_BITS-1:0] CTR_MAX  = {CTR_BITS{1'b1}};

  logic [HIST_BITS-1:0] histQ;
  logic [CTR_BITS-1:0]  ctrTab [ENTRIES];
  logic [CTR_BITS-1:0]  predCtr;

  // Index function chosen by parameter
  generate
    if (HASH_XOR) begin : g_hash
      assign predIdx = predPcIdx ^ IDX_W'(histQ);
    end else begin : g_join
      assign predIdx = {histQ, predPcIdx};
    end
  endgenerate

  assign predCtr   = ctrTab[predIdx];
  assign predTaken = predCtr[CTR_BITS-1];
  assign resCtr    = ctrTab[resIdx];

  // Global outcome history, updated only at resolve
  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (strb.histShift) begin
      histQ <= (histQ << 1) | HIST_BITS'(strb.histBit);
    end
  end

  // Saturating counter table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ctrTab[i] <= CTR_INIT;
      end
    end else if (strb.ctrWr) begin
      if (strb.ctrUp) begin
        ctrTab[resIdx] <= resCtr + 1'b1;
      end else begin
        ctrTab[resIdx] <= resCtr - 1'b1;
      end
    end
  end

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctrWr && strb.ctrUp) |-> (resCtr != CTR_MAX)); // R5

  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctrWr && !strb.ctrUp) |-> (resCtr != '0)); // R6

  AST_HIST_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strb.histShift |=> (histQ[0] == $past(strb.histBit))); // R4

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.histShift |=> $stable(histQ)); // R9

endmodule

// File: rtl/global_hist_predictor.sv
module global_hist_predictor
  import gbp_pkg::*;
#(
  parameter int HIST_BITS = 2,
  parameter int PC_BITS   = 4,
  parameter int CTR_BITS  = 2,
  parameter bit HASH_XOR  = 1'b0,
  localparam int IDX_W    = HASH_XOR ? PC_BITS : HIST_BITS + PC_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PC_BITS-1:0] predPcIdx,
  output logic               predTaken,
  output logic [IDX_W-1:0]   predIdx,
  input  logic               resValid,
  input  logic [IDX_W-1:0]   resIdx,
  input  logic               resTaken
);

  gbpStrobe_t          strb;
  logic [CTR_BITS-1:0] resCtr;

  gbp_ctrl #(
    .CTR_BITS (CTR_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .resValid (resValid),
    .resTaken (resTaken),
    .resCtr   (resCtr),
    .strb     (strb)
  );

  gbp_datapath #(
    .HIST_BITS (HIST_BITS),
    .PC_BITS   (PC_BITS),
    .CTR_BITS  (CTR_BITS),
    .HASH_XOR  (HASH_XOR),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .predPcIdx (predPcIdx),
    .predTaken (predTaken),
    .predIdx   (predIdx),
    .resIdx    (resIdx),
    .resCtr    (resCtr),
    .strb      (strb)
  );

endmodule

// File: tb/global_hist_predictor_bench.sv
module global_hist_predictor_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int total = 0;
  int bad = 0;

  // Joined-index instance (HIST=2, PC=4, n=2)
  logic [3:0] pcA;
  logic       predA;
  logic [5:0] idxA;
  logic       rvA;
  logic [5:0] riA;
  logic       rtA;

  global_hist_predictor #(.HASH_XOR(1'b0)) u_global_hist_predictor (
    .clk(clk), .rstN(rstN), .predPcIdx(pcA), .predTaken(predA), .predIdx(idxA),
    .resValid(rvA), .resIdx(riA), .resTaken(rtA));

  // Hashed-index instance (HIST=2, 16 entries)
  logic [3:0] pcB;
  logic       predB;
  logic [3:0] idxB;
  logic       rvB;
  logic [3:0] riB;
  logic       rtB;

  global_hist_predictor #(.HASH_XOR(1'b1)) u_global_hist_predictor_xor (
    .clk(clk), .rstN(rstN), .predPcIdx(pcB), .predTaken(predB), .predIdx(idxB),
    .resValid(rvB), .resIdx(riB), .resTaken(rtB));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] pc;
    logic       res;
    logic       tk;
    logic [5:0] idx;
    logic       pred;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'h3, 1'b1, 1'b1, 6'h03, 1'b0},  // R1 R2 fresh lookup
    '{4'h3, 1'b1, 1'b1, 6'h13, 1'b0},  // R4 history 01
    '{4'h3, 1'b1, 1'b0, 6'h33, 1'b0},  // R4 history 11
    '{4'h3, 1'b1, 1'b0, 6'h23, 1'b0},  // R4 history 10
    '{4'h3, 1'b1, 1'b1, 6'h03, 1'b1},  // R5 R7 counter 10
    '{4'h5, 1'b1, 1'b0, 6'h15, 1'b0},  // R8 other pc untouched
    '{4'h5, 1'b1, 1'b0, 6'h25, 1'b0},  // R8
    '{4'h3, 1'b1, 1'b1, 6'h03, 1'b1},  // R5 counter 11, taken again
    '{4'h3, 1'b0, 1'b0, 6'h13, 1'b1},  // R9 idle
    '{4'h3, 1'b0, 1'b0, 6'h13, 1'b1},  // R9 idle, nothing moved
    '{4'h3, 1'b1, 1'b0, 6'h13, 1'b1},  // R6 10 -> 01
    '{4'h3, 1'b1, 1'b0, 6'h23, 1'b0},  // R6 counter 00, not-taken again
    '{4'h0, 1'b0, 1'b0, 6'h00, 1'b0},  // R10 new pc same cycle
    '{4'h3, 1'b1, 1'b0, 6'h03, 1'b1},  // R5 still 11 (no wrap)
    '{4'h3, 1'b1, 1'b0, 6'h03, 1'b1},  // R5 10
    '{4'h3, 1'b1, 1'b1, 6'h03, 1'b0},  // R7 01
    '{4'h3, 1'b1, 1'b1, 6'h13, 1'b0},  // R8 entry 13 is 01
    '{4'h3, 1'b1, 1'b0, 6'h33, 1'b0},  // R6
    '{4'h3, 1'b1, 1'b1, 6'h23, 1'b0}   // R6 entry 23 stayed 00 (no wrap)
  };

  initial begin
    pcA = '0; rvA = 1'b0; riA = '0; rtA = 1'b0;
    pcB = '0; rvB = 1'b0; riB = '0; rtB = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    pcA = 4'hA; pcB = 4'hA;
    #1;
    check("R1 idx", 32'(idxA), 32'h0A);
    check("R1 pred", 32'(predA), 32'h0);
    check("R1 xor idx", 32'(idxB), 32'h0A);
    check("R1 xor pred", 32'(predB), 32'h0);

    // Vector walk on joined instance
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pcA = VECS[i].pc;
      rvA = VECS[i].res;
      rtA = VECS[i].tk;
      riA = VECS[i].idx;
      #1;
      check($sformatf("R2 R4 idx vec%0d", i), 32'(idxA), 32'(VECS[i].idx));
      check($sformatf("R7 pred vec%0d", i), 32'(predA), 32'(VECS[i].pred));
    end
    @(negedge clk);
    rvA = 1'b0;

    // R3 hashed index: history folded into pc bits
    pcB = 4'h5; rvB = 1'b1; riB = 4'h5; rtB = 1'b1;
    #1;
    check("R3 idx h00", 32'(idxB), 32'h5);
    @(negedge clk);
    pcB = 4'h5; riB = 4'h4; rtB = 1'b1;
    #1;
    check("R3 idx h01", 32'(idxB), 32'h4);
    check("R1 pred untouched entry", 32'(predB), 32'h0);
    @(negedge clk);
    rvB = 1'b0; pcB = 4'h5;
    #1;
    check("R3 idx h11", 32'(idxB), 32'h6);
    pcB = 4'h6;
    #1;
    check("R3 R8 entry5 taken", 32'(predB), 32'h1);
    check("R3 idx pc6", 32'(idxB), 32'h5);

    // R1 reset mid-run clears history and counters
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    pcA = 4'h3; pcB = 4'h6;
    #1;
    check("R1 hist cleared", 32'(idxA), 32'h03);
    check("R1 ctr cleared", 32'(predA), 32'h0);
    check("R1 xor cleared", 32'(predB), 32'h0);
    check("R1 xor hist cleared", 32'(idxB), 32'h6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule